// File: doc/BRIEF.md
# Dual-Mode Pseudorandom Generator and Response Compactor

This block is a three-stage shift register that serves two duties in a built-in test path. In generator mode it steps as a maximal-length linear feedback shift register. It emits a pseudorandom bit stream on a serial output and shows its whole state on a parallel output. In signature mode the same register also takes in a three-bit parallel word on every enabled cycle, folding each word into its state. After a long run of circuit responses, what remains is a short signature that a controller elsewhere can compare with a known value.

Stage 1 (state bit 0) receives the feedback, which is Q2 XOR Q3. Stage 2 takes the old Q1 and stage 3 takes the old Q2. The two modes differ only in whether a data bit is XORed into each stage's incoming value. A seed load sets the starting state. Because the all-zero state never leaves itself in generator mode, a zero seed is swapped for the value 3'b001.

Top module: `dual_lfsr_sig`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 3'b001 on that edge.
- R2: When `seed_load` is high and `rst` is low, the state takes a non-zero `seed_val` at the next edge, whatever `en`, `mode` and `par_in` are.
- R3: A seed load with `seed_val` = 3'b000 puts 3'b001 into the state.
- R4: With `rst`, `seed_load` and `en` all low, the state holds and `par_in` has no effect.
- R5: In generator mode (`mode` = 0) with `en` high, each edge gives Q1 ← Q2 XOR Q3, Q2 ← Q1, Q3 ← Q2, where Q1, Q2 and Q3 are state bits 0, 1 and 2.
- R6: From seed 3'b001, generator mode visits 010, 101, 011, 111, 110, 100 and returns to 001 after 7 steps without reaching zero. Over that period the serial output shows four ones and three zeros.
- R7: In signature mode (`mode` = 1) with `en` high, each state bit i becomes its generator-mode next value XOR `par_in[i]`.
- R8: Once the state is 3'b000, enabled generator-mode steps leave it at 3'b000.
- R9: `ser_out` always equals Q3 (state bit 2), and `state_out` always shows the full state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load `seed_val` into the state; overrides stepping |
| seed_val | input | 3 | Seed value; zero is replaced by 3'b001 |
| mode | input | 1 | 0 = generator, 1 = signature |
| en | input | 1 | Step enable; data is taken in only while high |
| par_in | input | 3 | Parallel data word, bit i joins stage i in signature mode |
| ser_out | output | 1 | Serial output, equal to Q3 |
| state_out | output | 3 | Current state, bit 0 = Q1 |

## Verification
Each result passes through exactly one register, so each one is due at the first rising edge after its inputs are set. Reset, load, hold, generator steps and signature folds all share this latency. The driver sets inputs at the falling edge and queues the value its own model predicts for the next rising edge. The monitor takes one entry per rising edge and compares it with `state_out` and `ser_out` one nanosecond after that edge, so the expected value and the observed value always refer to the same edge. The period and balance checks for R6 use serial-output values the monitor collected, not values from the model.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_SIG = 1'b1
  } lfsr_mode_e;

  // Value entering one stage: shifted bit, optionally folded with data.
  function automatic logic fold_bit(input logic shifted, input logic din,
                                    input logic sig_on);
    return shifted ^ (din & sig_on);
  endfunction

  // Parity of the tapped stages.
  function automatic logic tap_parity(input logic [31:0] st,
                                      input logic [31:0] taps);
    return ^(st & taps);
  endfunction

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next
  import lfsr_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b110
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  logic         sig_on,
  output logic [W-1:0] nxt,
  output logic         fb
);
  localparam int PAD = 32 - W;

  assign fb = tap_parity({{PAD{1'b0}}, cur}, {{PAD{1'b0}}, TAPS});

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic shifted;
    if (i == 0) begin : g_head
      assign shifted = fb;
    end else begin : g_body
      assign shifted = cur[i-1];
    end
    assign nxt[i] = fold_bit(shifted, din[i], sig_on);
  end

endmodule

// File: rtl/lfsr_seed_fix.sv
module lfsr_seed_fix #(
  parameter int W = 3,
  parameter logic [W-1:0] SUB = 3'b001
) (
  input  logic [W-1:0] seed,
  output logic [W-1:0] fixed,
  output logic         was_zero
);
  assign was_zero = (seed == '0);
  assign fixed    = was_zero ? SUB : seed;
endmodule

// File: rtl/dual_lfsr_sig.sv
module dual_lfsr_sig
  import lfsr_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b110,
  parameter logic [W-1:0] SUB  = 3'b001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic [W-1:0] seed_val,
  input  logic         mode,
  input  logic         en,
  input  logic [W-1:0] par_in,
  output logic         ser_out,
  output logic [W-1:0] state_out
);
  lfsr_mode_e   mode_e;
  logic [W-1:0] state_q;
  logic [W-1:0] step_val;
  logic [W-1:0] seed_ok;
  logic         fb_bit;
  logic         seed_zero;
  logic         load_ev;
  logic         step_ev;

  assign mode_e  = lfsr_mode_e'(mode);
  assign load_ev = !rst && seed_load;
  assign step_ev = !rst && !seed_load && en;

  lfsr_seed_fix #(.W(W), .SUB(SUB)) u_seed (
    .seed    (seed_val),
    .fixed   (seed_ok),
    .was_zero(seed_zero)
  );

  lfsr_next #(.W(W), .TAPS(TAPS)) u_next (
    .cur   (state_q),
    .din   (par_in),
    .sig_on(mode_e == MODE_SIG),
    .nxt   (step_val),
    .fb    (fb_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)          state_q <= SUB;
    else if (seed_load) state_q <= seed_ok;
    else if (en)      state_q <= step_val;
  end

  assign state_out = state_q;
  assign ser_out   = state_q[W-1];

endmodule

// File: rtl/dual_lfsr_sig_chk.sv
module dual_lfsr_sig_chk #(
  parameter int W = 3,
  parameter logic [W-1:0] SUB = 3'b001
) (
  input logic         clk,
  input logic         rst,
  input logic         mode,
  input logic [W-1:0] seed_val,
  input logic [W-1:0] state_out,
  input logic         ser_out,
  input logic         load_ev,
  input logic         step_ev,
  input logic         seed_zero
);
  AST_RESET_SEED: assert property (@(posedge clk) rst |=> state_out == SUB); // R1

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (load_ev && !seed_zero) |=> state_out == $past(seed_val)); // R2

  AST_ZERO_SEED_SUB: assert property (@(posedge clk) disable iff (rst)
    (load_ev && seed_zero) |=> state_out == SUB); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_ev && !step_ev) |=> $stable(state_out)); // R4

  AST_GEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !mode) |=> state_out[W-1:1] == $past(state_out[W-2:0])); // R5

  AST_GEN_NO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !mode && state_out != '0) |=> state_out != '0); // R6

  AST_GEN_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !mode && state_out == '0) |=> state_out == '0); // R8

  always_comb begin
    AST_SER_IS_Q3: assert (ser_out == state_out[W-1]); // R9
  end
endmodule

bind dual_lfsr_sig dual_lfsr_sig_chk #(.W(W), .SUB(SUB)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .seed_val (seed_val),
  .state_out(state_out),
  .ser_out  (ser_out),
  .load_ev  (load_ev),
  .step_ev  (step_ev),
  .seed_zero(seed_zero)
);

// File: tb/dual_lfsr_sig_tb.sv
module dual_lfsr_sig_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       seed_load = 0;
  logic [2:0] seed_val = 0;
  logic       mode = 0;
  logic       en = 0;
  logic [2:0] par_in = 0;
  logic       ser_out;
  logic [2:0] state_out;

  int vectors = 0;
  int fails = 0;
  int ones_seen = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic [2:0] mdl = 3'b001;

  always #5 clk = ~clk;

  dual_lfsr_sig u_dut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
    .mode(mode), .en(en), .par_in(par_in),
    .ser_out(ser_out), .state_out(state_out)
  );

  // Independent model: Q1 gets Q2^Q3, others move up one place.
  function automatic logic [2:0] model_step(logic [2:0] s, logic m, logic [2:0] d);
    logic [2:0] n;
    n[0] = s[1] ^ s[2];
    n[1] = s[0];
    n[2] = s[1];
    if (m) n = n ^ d;
    return n;
  endfunction

  task automatic apply(logic r, logic ld, logic [2:0] sv, logic m, logic e,
                       logic [2:0] d, string tag);
    item_t it;
    @(negedge clk);
    rst = r; seed_load = ld; seed_val = sv; mode = m; en = e; par_in = d;
    if (r)        mdl = 3'b001;
    else if (ld)  mdl = (sv == 3'b000) ? 3'b001 : sv;
    else if (e)   mdl = model_step(mdl, m, d);
    it.exp = mdl; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vectors++;
      if (state_out !== it.exp) begin
        fails++;
        $display("FAIL %s state_out actual=%b expected=%b", it.tag, state_out, it.exp);
      end
      if (ser_out !== it.exp[2]) begin
        fails++;
        $display("FAIL R9 ser_out actual=%b expected=%b (%s)", ser_out, it.exp[2], it.tag);
      end
      if (it.tag == "R6") ones_seen += int'(ser_out);
    end
  end

  task automatic check_val(int act, int exp, string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    // R1: reset state
    apply(1, 0, 3'b000, 0, 0, 3'b000, "R1");
    apply(1, 1, 3'b110, 1, 1, 3'b111, "R1");
    // R6: full generator period from 001, checked step by step (R5)
    for (int k = 0; k < 7; k++) apply(0, 0, 3'b000, 0, 1, 3'b101, "R6");
    apply(0, 0, 3'b000, 0, 0, 3'b000, "R4");
    @(negedge clk);
    check_val(int'(state_out), 1, "R6 period returns to seed");
    check_val(ones_seen, 4, "R6 ones in period");
    // R4: idle with data and signature mode held
    apply(0, 0, 3'b111, 1, 0, 3'b111, "R4");
    apply(0, 0, 3'b010, 1, 0, 3'b101, "R4");
    // R2: load beats enabled step
    apply(0, 1, 3'b101, 1, 1, 3'b111, "R2");
    apply(0, 0, 3'b000, 0, 1, 3'b000, "R5");
    apply(0, 0, 3'b000, 0, 1, 3'b000, "R5");
    apply(0, 1, 3'b110, 0, 0, 3'b000, "R2");
    apply(0, 0, 3'b000, 0, 1, 3'b011, "R5");
    // R3: zero seed replaced
    apply(0, 1, 3'b000, 0, 1, 3'b000, "R3");
    // R7: signature folds with varied data
    apply(0, 0, 3'b000, 1, 1, 3'b001, "R7");
    apply(0, 0, 3'b000, 1, 1, 3'b110, "R7");
    apply(0, 0, 3'b000, 1, 1, 3'b011, "R7");
    apply(0, 0, 3'b000, 1, 1, 3'b100, "R7");
    apply(0, 0, 3'b000, 1, 1, 3'b000, "R7");
    // R8: drive state to zero, then generator stays locked
    apply(0, 1, 3'b001, 0, 0, 3'b000, "R2");
    apply(0, 0, 3'b000, 1, 1, 3'b010, "R7");
    for (int k = 0; k < 3; k++) apply(0, 0, 3'b000, 0, 1, 3'b111, "R8");
    // Signature mode can leave zero through data
    apply(0, 0, 3'b000, 1, 1, 3'b100, "R7");
    apply(1, 0, 3'b000, 0, 0, 3'b000, "R1");
    apply(0, 0, 3'b000, 0, 0, 3'b000, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule